// File: doc/BRIEF.md
# Latched Interrupt Controller

This block collects up to 32 interrupt request lines for a processor core. Every request is caught in a status latch. The latch is combined with an enable mask, and the result is reduced to one registered interrupt output for the core. That output only rises while the core's global interrupt-enable input is high.

Software uses a small register port to reach the mask and the status latch. It writes the status latch to acknowledge a line. A parameter chooses the acknowledge convention: a written 1 clears the bit, or a written 0 clears the bit. The second convention lets a handler write back the value it read, with only the serviced bit dropped.

Each line is either edge-sensed or level-sensed, chosen per bit by a parameter. Both kinds stay latched until software clears them. A scan output reports the lowest enabled pending line at or above a software-chosen start index. A dispatch loop can therefore walk the pending lines in ascending order.

Top module: `irq_latch_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the mask reads 0, the status reads 0, `cpu_irq` is 0 and `scan_hit` is 0.
- R2: A write with `cfg_sel`=0 loads the whole mask from `cfg_wdata` at the clock edge. A read with `cfg_sel`=0 returns the mask and `cfg_sel`=1 returns the status; the read path is combinational.
- R3: A line whose `EDGE_LINES` bit is 0 (level-sensed; bits 15..0 by default) sets its status bit at every edge where it is high. The bit stays set after the line drops.
- R4: A line whose `EDGE_LINES` bit is 1 (edge-sensed; bits 31..16 by default) sets its status bit only at the first edge where it is high after an edge where it was low. Holding it high does not set the bit again once it has been cleared.
- R5: With `CLEAR_ON_ZERO`=0 (the default), a status write clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: With `CLEAR_ON_ZERO`=1, a status write clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: If a line requests a set at the same edge that a status write clears its bit, the bit stays set.
- R8: At each clock edge, `cpu_irq` takes the value (`int_enable` AND the OR of status AND mask) as it stood just before that edge. A masked pending line therefore never raises it.
- R9: `scan_hit` is 1 exactly when some bit of status AND mask at index `scan_base` or higher is set. `scan_idx` is then the lowest such index; otherwise `scan_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Interrupt request lines |
| int_enable | input | 1 | Global interrupt enable from the core status word |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 mask, 1 status |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| scan_base | input | 5 | Lowest index the scan considers |
| scan_idx | output | 5 | Lowest enabled pending index at or above `scan_base` |
| scan_hit | output | 1 | Scan found an enabled pending line |
| cpu_irq | output | 1 | Registered interrupt request to the core |

## Verification
A request or a register write driven before clock edge N is visible in the status or mask read-back, and on the scan outputs, right after edge N. `cpu_irq` follows one edge later, at N+1. The bench drives every input on the falling clock and samples on the next falling clock. Status and scan results are checked one edge after their stimulus. `cpu_irq` is checked both at that sample, where it must still be 0, and one edge later, where it must be high.

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int          N             = 32,
  parameter int          IDX_W         = $clog2(N),
  parameter bit          CLEAR_ON_ZERO = 1'b0,
  parameter logic [N-1:0] EDGE_LINES   = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_lines,
  input  logic             int_enable,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [N-1:0]     cfg_wdata,
  output logic [N-1:0]     cfg_rdata,
  input  logic [IDX_W-1:0] scan_base,
  output logic [IDX_W-1:0] scan_idx,
  output logic             scan_hit,
  output logic             cpu_irq
);

  localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

  logic [N-1:0] mask_q, status_q, line_prev;
  logic [N-1:0] set_vec, clr_vec, pending, window;

  // edge lines fire on a low-to-high step, level lines whenever high
  assign set_vec = (irq_lines & ~EDGE_LINES) | (irq_lines & ~line_prev & EDGE_LINES);

  generate
    if (CLEAR_ON_ZERO) begin : g_clr_zero
      assign clr_vec = (cfg_we && cfg_sel) ? ~cfg_wdata : '0;
    end else begin : g_clr_one
      assign clr_vec = (cfg_we && cfg_sel) ? cfg_wdata : '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      status_q  <= '0;
      line_prev <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      line_prev <= irq_lines;
      status_q  <= (status_q & ~clr_vec) | set_vec;
      if (cfg_we && !cfg_sel) mask_q <= cfg_wdata;
      cpu_irq   <= int_enable && (|(status_q & mask_q));
    end
  end

  assign cfg_rdata = cfg_sel ? status_q : mask_q;
  assign pending   = status_q & mask_q;
  assign window    = pending & (ALL_ONES << scan_base);

  always_comb begin
    scan_idx = '0;
    scan_hit = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (window[i]) begin
        scan_idx = IDX_W'(i);
        scan_hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
  parameter int           N             = 32,
  parameter int           IDX_W         = $clog2(N),
  parameter bit           CLEAR_ON_ZERO = 1'b0,
  parameter logic [N-1:0] EDGE_LINES    = 32'hFFFF_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     irq_lines,
  input logic             int_enable,
  input logic             cfg_we,
  input logic             cfg_sel,
  input logic [N-1:0]     cfg_wdata,
  input logic [N-1:0]     mask_q,
  input logic [N-1:0]     status_q,
  input logic [N-1:0]     line_prev,
  input logic [IDX_W-1:0] scan_base,
  input logic [IDX_W-1:0] scan_idx,
  input logic             scan_hit,
  input logic             cpu_irq
);

  logic [N-1:0] lvl_req, new_req, wr_clear, seen;
  assign lvl_req  = irq_lines & ~EDGE_LINES;
  assign new_req  = lvl_req | (irq_lines & EDGE_LINES & ~line_prev);
  assign wr_clear = CLEAR_ON_ZERO ? ~cfg_wdata : cfg_wdata;
  assign seen     = status_q & mask_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '0 && status_q == '0 && !cpu_irq));

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (mask_q == $past(cfg_wdata)));

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_req != '0) |=> ((status_q & $past(lvl_req)) == $past(lvl_req)));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> ((status_q & $past(wr_clear & ~new_req)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (new_req != '0) |=> ((status_q & $past(new_req)) == $past(new_req)));

  // R8
  core_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == $past(int_enable && (seen != '0))));

  // R9
  scan_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_hit |-> (seen[scan_idx] && scan_idx >= scan_base));

endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(
  .N(N), .IDX_W(IDX_W), .CLEAR_ON_ZERO(CLEAR_ON_ZERO), .EDGE_LINES(EDGE_LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .int_enable(int_enable),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .mask_q(mask_q), .status_q(status_q), .line_prev(line_prev),
  .scan_base(scan_base), .scan_idx(scan_idx), .scan_hit(scan_hit),
  .cpu_irq(cpu_irq)
);

// File: tb/irq_latch_ctrl_tb.sv
module irq_latch_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        int_enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [4:0]  scan_base = '0;
  logic [31:0] cfg_rdata, alt_rdata;
  logic [4:0]  scan_idx, alt_idx;
  logic        scan_hit, alt_hit, cpu_irq, alt_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_latch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .int_enable(int_enable),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .scan_base(scan_base), .scan_idx(scan_idx), .scan_hit(scan_hit), .cpu_irq(cpu_irq)
  );

  irq_latch_ctrl #(.CLEAR_ON_ZERO(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .int_enable(int_enable),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(alt_rdata),
    .scan_base(scan_base), .scan_idx(alt_idx), .scan_hit(alt_hit), .cpu_irq(alt_irq)
  );

  // irq, we_status, wdata, base, exp_status, exp_hit, exp_idx
  typedef struct packed {
    logic [31:0] irq;
    logic        we;
    logic [31:0] wdata;
    logic [4:0]  base;
    logic [31:0] exp_st;
    logic        exp_hit;
    logic [4:0]  exp_idx;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0004, 1'b0, 32'h0,         5'd0, 32'h0000_0004, 1'b1, 5'd2},
    '{32'h0000_0000, 1'b0, 32'h0,         5'd3, 32'h0000_0004, 1'b0, 5'd0},
    '{32'h0000_0000, 1'b1, 32'h0000_0004, 5'd0, 32'h0000_0000, 1'b0, 5'd0},
    '{32'h0001_0000, 1'b0, 32'h0,         5'd0, 32'h0001_0000, 1'b1, 5'd16},
    '{32'h0001_0000, 1'b1, 32'h0001_0000, 5'd0, 32'h0000_0000, 1'b0, 5'd0},
    '{32'h0001_0000, 1'b0, 32'h0,         5'd0, 32'h0000_0000, 1'b0, 5'd0},
    '{32'h0000_0000, 1'b0, 32'h0,         5'd0, 32'h0000_0000, 1'b0, 5'd0},
    '{32'h0001_0008, 1'b0, 32'h0,         5'd4, 32'h0001_0008, 1'b1, 5'd16},
    '{32'h0000_0008, 1'b1, 32'h0000_0008, 5'd0, 32'h0001_0008, 1'b1, 5'd3},
    '{32'h0000_0000, 1'b1, 32'h0000_0000, 5'd0, 32'h0001_0008, 1'b1, 5'd3},
    '{32'h0000_0000, 1'b1, 32'h0001_0008, 5'd0, 32'h0000_0000, 1'b0, 5'd0},
    '{32'h8000_0001, 1'b0, 32'h0,         5'd1, 32'h8000_0001, 1'b1, 5'd31},
    '{32'h0000_0000, 1'b1, 32'h0000_0001, 5'd0, 32'h8000_0000, 1'b1, 5'd31},
    '{32'h0000_0000, 1'b1, 32'h8000_0000, 5'd0, 32'h0000_0000, 1'b0, 5'd0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on the falling edge, let one rising edge pass, return at the next falling edge
  task automatic cycle(logic [31:0] irq, logic we, logic sel, logic [31:0] wd);
    irq_lines = irq; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cfg_sel = 1'b0; #1;
    check("R1 mask at reset", cfg_rdata, 32'h0);
    cfg_sel = 1'b1; #1;
    check("R1 status at reset", cfg_rdata, 32'h0);
    check("R1 irq/hit at reset", {30'h0, cpu_irq, scan_hit}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after release", cfg_rdata, 32'h0);

    // R2 mask write and read-back
    cycle(32'h0, 1'b1, 1'b0, 32'hA5A5_0F0F);
    cfg_sel = 1'b0; #1;
    check("R2 mask readback", cfg_rdata, 32'hA5A5_0F0F);
    cycle(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFF);

    // table walk: R3 R4 R5 R7 R9
    for (int k = 0; k < NV; k++) begin
      scan_base = VECS[k].base;
      cycle(VECS[k].irq, VECS[k].we, 1'b1, VECS[k].wdata);
      cfg_sel = 1'b1; #1;
      check($sformatf("R3/R4/R5/R7 status step %0d", k), cfg_rdata, VECS[k].exp_st);
      check($sformatf("R9 scan step %0d", k), {26'h0, scan_hit, scan_idx},
            {26'h0, VECS[k].exp_hit, VECS[k].exp_idx});
    end
    scan_base = '0;

    // R8 masked pending line does not reach the core
    int_enable = 1'b1;
    cycle(32'h0, 1'b1, 1'b0, 32'h0);
    cycle(32'h0000_0020, 1'b0, 1'b1, 32'h0);
    cycle(32'h0, 1'b0, 1'b1, 32'h0);
    #1;
    check("R8 masked irq stays low", {31'h0, cpu_irq}, 32'h0);
    check("R9 masked line no hit", {31'h0, scan_hit}, 32'h0);
    cycle(32'h0, 1'b1, 1'b0, 32'h0000_0020);
    #1;
    check("R8 irq one edge after mask", {31'h0, cpu_irq}, 32'h0);
    @(negedge clk); #1;
    check("R8 irq raised", {31'h0, cpu_irq}, 32'h1);
    int_enable = 1'b0;
    @(negedge clk); #1;
    check("R8 irq gated by enable", {31'h0, cpu_irq}, 32'h0);
    cycle(32'h0, 1'b1, 1'b1, 32'hFFFF_FFFF);

    // R6 clear-on-zero variant against R5 default
    cycle(32'h0000_0030, 1'b0, 1'b1, 32'h0);
    cycle(32'h0, 1'b1, 1'b1, 32'hFFFF_FFEF);
    cfg_sel = 1'b1; #1;
    check("R6 zero clears bit4", alt_rdata, 32'h0000_0020);
    check("R5 ones clear others", cfg_rdata, 32'h0000_0010);
    cycle(32'h0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    cfg_sel = 1'b1; #1;
    check("R6 ones leave status", alt_rdata, 32'h0000_0020);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule